// File: doc/BRIEF.md
# Message Interrupt Source Layer

This block is the source side of a two-level interrupt scheme. It owns a parameterized set of message-style interrupt sources. Each source is known outside the block by a global number, which is its index plus a fixed base of 16. Each source holds a destination server index and an 8-bit priority. The priority value 0xFF means the source is masked, and every source comes out of reset masked.

A rising edge on a source's trigger line becomes a delivery to the presentation logic. A delivery carries the global number, the priority and the server. If the source is masked, the edge is remembered instead and is replayed when a configuration write unmasks the source. The presentation logic can hand a delivery back as rejected. Rejected sources are remembered and offered again when a resend request arrives.

Configuration goes through a write/read port that checks its arguments and answers one cycle later with a status byte. End-of-interrupt notifications are acknowledged and change nothing. All deliveries pass through one output that carries at most one source per cycle.

Top module: `msgirq_top`

## Requirements
- R1: After reset every source reads back priority 0xFF and server 0, no delivery is presented and `queueBusy` is low.
- R2: A source number is valid only when it is at least 16 and below 16 plus `NUM_SRC`. A configuration read of an invalid number answers status 0xFD, and 0 on server and priority.
- R3: A configuration write is refused with status 0xFD, and changes no state, when the number is invalid, when the server is not below `NUM_SERVERS`, or when the priority exceeds 0xFF. Otherwise it answers status 0x00 and stores server and priority.
- R4: Each configuration request is answered on `respValid` exactly one cycle later. A valid read returns status 0x00 with the stored server and priority.
- R5: A rising edge on the trigger line of an unmasked source presents that source on the delivery output from the next cycle, with global number, priority and server. A trigger line held high does not trigger again.
- R6: A trigger on a masked source produces no delivery and is remembered. A later write that sets a priority other than 0xFF presents the source in the cycle after the write. A write that keeps 0xFF keeps it pending.
- R7: A reject of a valid number marks that source. A resend request clears every mark and queues each marked source that is unmasked. A second resend with no new reject queues nothing.
- R8: A rejected source that is masked when the resend arrives loses its mark and is not delivered, even after a later unmask.
- R9: At most one source is presented per cycle. Queued sources leave in ascending number order, one per cycle.
- R10: An end-of-interrupt for a valid number raises `eoiAck` for one cycle and changes neither configuration nor deliveries. An invalid number is not acknowledged.
- R11: `queueBusy` is high whenever a delivery is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigIn | input | NUM_SRC | Per-source trigger lines, rising edge active |
| cfgWr | input | 1 | Configuration write request |
| cfgRd | input | 1 | Configuration read request (a write wins if both are set) |
| cfgNum | input | NUM_W | Global source number for the request |
| cfgServer | input | NUM_W | Server index to store |
| cfgPrio | input | NUM_W | Priority to store; above 0xFF is refused |
| respValid | output | 1 | Response strobe, one cycle after a request |
| respStatus | output | 8 | 0x00 accepted, 0xFD refused |
| respServer | output | SRV_W | Server read back (0 unless a valid read) |
| respPrio | output | 8 | Priority read back (0 unless a valid read) |
| rejValid | input | 1 | Presentation logic rejects a source |
| rejNum | input | NUM_W | Global number being rejected |
| resendReq | input | 1 | Re-offer all rejected sources |
| eoiValid | input | 1 | End-of-interrupt notification |
| eoiNum | input | NUM_W | Global number of the finished interrupt |
| eoiAck | output | 1 | Acknowledge of a valid end-of-interrupt |
| dlvValid | output | 1 | A delivery is presented this cycle |
| dlvNum | output | NUM_W | Global number of the delivered source |
| dlvPrio | output | 8 | Priority of the delivered source |
| dlvServer | output | SRV_W | Destination server of the delivered source |
| queueBusy | output | 1 | Some source is queued for delivery |

## Verification
The bench builds the block with six sources and three servers. Both counts are not powers of two, so the index width can name sources that do not exist, and the server width can hold a server index that the range check must refuse. Using six sources also puts the upper edge of the number range (21 accepted, 22 refused) within a few cycles of reset. It lets a single burst of triggers fill most of the queue, which exercises the ascending one-per-cycle order.

// File: rtl/msgirq_pkg.sv
package msgirq_pkg;
  localparam logic [7:0] PRIO_OFF   = 8'hFF;
  localparam logic [7:0] STATUS_OK  = 8'h00;
  localparam logic [7:0] STATUS_BAD = 8'hFD;

  // strobes from the control decode to the datapath
  typedef struct packed {
    logic wrOk;
    logic rdOk;
    logic cfgOp;
    logic rejOk;
    logic resendGo;
  } strobe_t;
endpackage

// File: rtl/msgirq_ctrl.sv
module msgirq_ctrl
  import msgirq_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int NUM_SERVERS = 4,
  parameter int BASE        = 16,
  parameter int NUM_W       = 16,
  parameter int IDX_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic             cfgRd,
  input  logic [NUM_W-1:0] cfgNum,
  input  logic [NUM_W-1:0] cfgServer,
  input  logic [NUM_W-1:0] cfgPrio,
  input  logic             rejValid,
  input  logic [NUM_W-1:0] rejNum,
  input  logic             resendReq,
  input  logic             eoiValid,
  input  logic [NUM_W-1:0] eoiNum,
  output strobe_t          strobe,
  output logic [IDX_W-1:0] cfgIdx,
  output logic [IDX_W-1:0] rejIdx,
  output logic             respValid,
  output logic [7:0]       respStatus,
  output logic             eoiAck
);
  function automatic logic numOk(input logic [NUM_W-1:0] n);
    logic [NUM_W-1:0] off;
    off = n - NUM_W'(BASE);
    return (n >= NUM_W'(BASE)) && (off < NUM_W'(NUM_SRC));
  endfunction

  logic cfgNumOk;

  always_comb begin
    cfgNumOk        = numOk(cfgNum);
    cfgIdx          = IDX_W'(cfgNum - NUM_W'(BASE));
    rejIdx          = IDX_W'(rejNum - NUM_W'(BASE));
    strobe.wrOk     = cfgWr && cfgNumOk && (cfgServer < NUM_W'(NUM_SERVERS))
                      && (cfgPrio <= NUM_W'(255));
    strobe.rdOk     = cfgRd && !cfgWr && cfgNumOk;
    strobe.cfgOp    = cfgWr || cfgRd;
    strobe.rejOk    = rejValid && numOk(rejNum);
    strobe.resendGo = resendReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respStatus <= STATUS_OK;
      eoiAck     <= 1'b0;
    end else begin
      respValid <= strobe.cfgOp;
      if (strobe.cfgOp)
        respStatus <= (strobe.wrOk || strobe.rdOk) ? STATUS_OK : STATUS_BAD;
      eoiAck <= eoiValid && numOk(eoiNum);
    end
  end
endmodule

// File: rtl/msgirq_datapath.sv
module msgirq_datapath
  import msgirq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int BASE    = 16,
  parameter int NUM_W   = 16,
  parameter int IDX_W   = 4,
  parameter int SRV_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic [IDX_W-1:0]   rejIdx,
  input  logic [SRV_W-1:0]   wrServer,
  input  logic [7:0]         wrPrio,
  input  logic [NUM_SRC-1:0] trigIn,
  output logic [SRV_W-1:0]   rdServer,
  output logic [7:0]         rdPrio,
  output logic               dlvValid,
  output logic [NUM_W-1:0]   dlvNum,
  output logic [7:0]         dlvPrio,
  output logic [SRV_W-1:0]   dlvServer,
  output logic               queueBusy
);
  logic [NUM_SRC*8-1:0]     prioFlat;
  logic [NUM_SRC*SRV_W-1:0] srvFlat;
  logic [NUM_SRC-1:0]       queued, eligible, grant;
  logic [IDX_W-1:0]         grantIdx;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic [7:0]       prioR;
    logic [SRV_W-1:0] srvR;
    logic             maskPendR, rejR, queueR, trigPrevR;
    logic             wrHit, rejHit, rise, effMasked;

    always_comb begin
      wrHit     = strobe.wrOk && (cfgIdx == IDX_W'(g));
      rejHit    = strobe.rejOk && (rejIdx == IDX_W'(g));
      rise      = trigIn[g] && !trigPrevR;
      effMasked = (wrHit ? wrPrio : prioR) == PRIO_OFF;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prioR     <= PRIO_OFF;
        srvR      <= '0;
        maskPendR <= 1'b0;
        rejR      <= 1'b0;
        queueR    <= 1'b0;
        trigPrevR <= 1'b0;
      end else begin
        trigPrevR <= trigIn[g];
        if (wrHit) begin
          prioR <= wrPrio;
          srvR  <= wrServer;
        end
        if (rise && effMasked)
          maskPendR <= 1'b1;
        else if (wrHit && !effMasked)
          maskPendR <= 1'b0;
        if (rejHit)
          rejR <= 1'b1;
        else if (strobe.resendGo)
          rejR <= 1'b0;
        if (!effMasked && (rise || (wrHit && maskPendR) || (strobe.resendGo && rejR)))
          queueR <= 1'b1;
        else if (grant[g])
          queueR <= 1'b0;
      end
    end

    assign prioFlat[g*8 +: 8]         = prioR;
    assign srvFlat[g*SRV_W +: SRV_W]  = srvR;
    assign queued[g]                  = queueR;
    assign eligible[g]                = queueR && (prioR != PRIO_OFF);
  end

  // lowest set bit wins
  assign grant = eligible & (~eligible + 1'b1);

  always_comb begin
    grantIdx = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (grant[i]) grantIdx = IDX_W'(i);
  end

  assign dlvValid  = |eligible;
  assign dlvNum    = NUM_W'(BASE) + NUM_W'(grantIdx);
  assign dlvPrio   = prioFlat[grantIdx*8 +: 8];
  assign dlvServer = srvFlat[grantIdx*SRV_W +: SRV_W];
  assign queueBusy = |queued;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdServer <= '0;
      rdPrio   <= '0;
    end else if (strobe.cfgOp) begin
      rdServer <= strobe.rdOk ? srvFlat[cfgIdx*SRV_W +: SRV_W] : '0;
      rdPrio   <= strobe.rdOk ? prioFlat[cfgIdx*8 +: 8] : '0;
    end
  end
endmodule

// File: rtl/msgirq_top.sv
module msgirq_top
  import msgirq_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int NUM_SERVERS = 4,
  parameter int BASE        = 16,
  parameter int NUM_W       = 16,
  localparam int IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int SRV_W      = (NUM_SERVERS > 1) ? $clog2(NUM_SERVERS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] trigIn,
  input  logic               cfgWr,
  input  logic               cfgRd,
  input  logic [NUM_W-1:0]   cfgNum,
  input  logic [NUM_W-1:0]   cfgServer,
  input  logic [NUM_W-1:0]   cfgPrio,
  output logic               respValid,
  output logic [7:0]         respStatus,
  output logic [SRV_W-1:0]   respServer,
  output logic [7:0]         respPrio,
  input  logic               rejValid,
  input  logic [NUM_W-1:0]   rejNum,
  input  logic               resendReq,
  input  logic               eoiValid,
  input  logic [NUM_W-1:0]   eoiNum,
  output logic               eoiAck,
  output logic               dlvValid,
  output logic [NUM_W-1:0]   dlvNum,
  output logic [7:0]         dlvPrio,
  output logic [SRV_W-1:0]   dlvServer,
  output logic               queueBusy
);
  strobe_t          strobe;
  logic [IDX_W-1:0] cfgIdx, rejIdx;

  msgirq_ctrl #(
    .NUM_SRC(NUM_SRC), .NUM_SERVERS(NUM_SERVERS), .BASE(BASE),
    .NUM_W(NUM_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgRd(cfgRd),
    .cfgNum(cfgNum), .cfgServer(cfgServer), .cfgPrio(cfgPrio),
    .rejValid(rejValid), .rejNum(rejNum), .resendReq(resendReq),
    .eoiValid(eoiValid), .eoiNum(eoiNum), .strobe(strobe),
    .cfgIdx(cfgIdx), .rejIdx(rejIdx), .respValid(respValid),
    .respStatus(respStatus), .eoiAck(eoiAck)
  );

  msgirq_datapath #(
    .NUM_SRC(NUM_SRC), .BASE(BASE), .NUM_W(NUM_W),
    .IDX_W(IDX_W), .SRV_W(SRV_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgIdx(cfgIdx),
    .rejIdx(rejIdx), .wrServer(cfgServer[SRV_W-1:0]),
    .wrPrio(cfgPrio[7:0]), .trigIn(trigIn), .rdServer(respServer),
    .rdPrio(respPrio), .dlvValid(dlvValid), .dlvNum(dlvNum),
    .dlvPrio(dlvPrio), .dlvServer(dlvServer), .queueBusy(queueBusy)
  );
endmodule

// File: rtl/msgirq_chk.sv
module msgirq_chk #(
  parameter int NUM_SRC = 16,
  parameter int BASE    = 16,
  parameter int NUM_W   = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWr,
  input logic             cfgRd,
  input logic [NUM_W-1:0] cfgPrio,
  input logic             respValid,
  input logic [7:0]       respStatus,
  input logic             eoiValid,
  input logic [NUM_W-1:0] eoiNum,
  input logic             eoiAck,
  input logic             dlvValid,
  input logic [NUM_W-1:0] dlvNum,
  input logic [7:0]       dlvPrio,
  input logic             queueBusy
);
  // R2
  dlv_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    dlvValid |-> (dlvNum >= NUM_W'(BASE)) && (dlvNum < NUM_W'(BASE + NUM_SRC)));

  // R6
  dlv_unmasked_chk: assert property (@(posedge clk) disable iff (!rstN)
    dlvValid |-> dlvPrio != 8'hFF);

  // R3
  bad_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && (cfgPrio > NUM_W'(255))) |=> respValid && (respStatus == 8'hFD));

  // R4
  resp_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr || cfgRd) |=> respValid);

  // R4
  resp_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWr || cfgRd) |=> !respValid);

  // R10
  eoi_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eoiValid && (eoiNum == NUM_W'(BASE))) |=> eoiAck);

  // R11
  busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    dlvValid |-> queueBusy);
endmodule

bind msgirq_top msgirq_chk #(.NUM_SRC(NUM_SRC), .BASE(BASE), .NUM_W(NUM_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgRd(cfgRd), .cfgPrio(cfgPrio),
  .respValid(respValid), .respStatus(respStatus), .eoiValid(eoiValid),
  .eoiNum(eoiNum), .eoiAck(eoiAck), .dlvValid(dlvValid), .dlvNum(dlvNum),
  .dlvPrio(dlvPrio), .queueBusy(queueBusy)
);

// File: tb/msgirq_top_test.sv
`timescale 1ns/1ps
module msgirq_top_test;
  localparam int N  = 6;
  localparam int S  = 3;
  localparam int B  = 16;
  localparam int W  = 16;
  localparam int SW = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic [N-1:0] trigIn = '0;
  logic cfgWr = 0, cfgRd = 0, rejValid = 0, resendReq = 0, eoiValid = 0;
  logic [W-1:0] cfgNum = '0, cfgServer = '0, cfgPrio = '0, rejNum = '0, eoiNum = '0;
  logic respValid, eoiAck, dlvValid, queueBusy;
  logic [7:0] respStatus, respPrio, dlvPrio;
  logic [SW-1:0] respServer, dlvServer;
  logic [W-1:0] dlvNum;

  always #2 clk = ~clk;

  msgirq_top #(.NUM_SRC(N), .NUM_SERVERS(S), .BASE(B), .NUM_W(W)) uut (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .cfgWr(cfgWr), .cfgRd(cfgRd),
    .cfgNum(cfgNum), .cfgServer(cfgServer), .cfgPrio(cfgPrio),
    .respValid(respValid), .respStatus(respStatus), .respServer(respServer),
    .respPrio(respPrio), .rejValid(rejValid), .rejNum(rejNum),
    .resendReq(resendReq), .eoiValid(eoiValid), .eoiNum(eoiNum),
    .eoiAck(eoiAck), .dlvValid(dlvValid), .dlvNum(dlvNum), .dlvPrio(dlvPrio),
    .dlvServer(dlvServer), .queueBusy(queueBusy)
  );

  int tests = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural reference
  int  mPrio[N], mSrv[N];
  bit  mMask[N], mRej[N], mQ[N], mPrev[N];
  bit  eRespV, eAck;
  int  eStat, eRdSrv, eRdPrio;

  function automatic bit inRange(int n);
    return n >= B && n < B + N;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        mPrio[i] = 255; mSrv[i] = 0; mMask[i] = 0; mRej[i] = 0; mQ[i] = 0; mPrev[i] = 0;
      end
      eRespV = 0; eAck = 0; eStat = 0; eRdSrv = 0; eRdPrio = 0;
    end else begin
      int g; bit wOk; int ci;
      g = -1;
      for (int i = N - 1; i >= 0; i--) if (mQ[i] && mPrio[i] != 255) g = i;
      ci = int'(cfgNum) - B;
      wOk = cfgWr && inRange(int'(cfgNum)) && int'(cfgServer) < S && int'(cfgPrio) <= 255;
      eRespV = cfgWr || cfgRd;
      if (cfgWr) begin
        eStat = wOk ? 0 : 8'hFD; eRdSrv = 0; eRdPrio = 0;
      end else if (cfgRd) begin
        if (inRange(int'(cfgNum))) begin eStat = 0; eRdSrv = mSrv[ci]; eRdPrio = mPrio[ci]; end
        else begin eStat = 8'hFD; eRdSrv = 0; eRdPrio = 0; end
      end
      eAck = eoiValid && inRange(int'(eoiNum));
      for (int i = 0; i < N; i++) begin
        bit hit, rise, off, rj;
        hit  = wOk && ci == i;
        rise = trigIn[i] && !mPrev[i];
        off  = (hit ? int'(cfgPrio) : mPrio[i]) == 255;
        rj   = rejValid && inRange(int'(rejNum)) && int'(rejNum) - B == i;
        if (g == i) mQ[i] = 0;
        if (!off && (rise || (hit && mMask[i]) || (resendReq && mRej[i]))) mQ[i] = 1;
        if (rise && off) mMask[i] = 1; else if (hit && !off) mMask[i] = 0;
        if (rj) mRej[i] = 1; else if (resendReq) mRej[i] = 0;
        if (hit) begin mPrio[i] = int'(cfgPrio); mSrv[i] = int'(cfgServer); end
        mPrev[i] = trigIn[i];
      end
    end
  end

  task automatic check(string t, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", t, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rstN && !done) begin
    int g; bit busy;
    g = -1; busy = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mQ[i] && mPrio[i] != 255) g = i;
      if (mQ[i]) busy = 1;
    end
    check({tag, " dlvValid"}, int'(dlvValid), int'(g >= 0));
    if (g >= 0) begin
      check({tag, " dlvNum"}, int'(dlvNum), g + B);
      check({tag, " dlvPrio"}, int'(dlvPrio), mPrio[g]);
      check({tag, " dlvServer"}, int'(dlvServer), mSrv[g]);
    end
    check({tag, " R11 queueBusy"}, int'(queueBusy), int'(busy));
    check({tag, " respValid"}, int'(respValid), int'(eRespV));
    if (eRespV) begin
      check({tag, " respStatus"}, int'(respStatus), eStat);
      check({tag, " respServer"}, int'(respServer), eRdSrv);
      check({tag, " respPrio"}, int'(respPrio), eRdPrio);
    end
    check({tag, " eoiAck"}, int'(eoiAck), int'(eAck));
  end

  task automatic cfgOp(bit wr, int num, int srv, int prio);
    @(negedge clk);
    cfgWr = wr; cfgRd = !wr; cfgNum = W'(num); cfgServer = W'(srv); cfgPrio = W'(prio);
    @(negedge clk);
    cfgWr = 0; cfgRd = 0;
  endtask

  task automatic pulse(logic [N-1:0] m);
    @(negedge clk); trigIn = m;
    @(negedge clk); trigIn = '0;
  endtask

  task automatic reject(int num);
    @(negedge clk); rejValid = 1; rejNum = W'(num);
    @(negedge clk); rejValid = 0;
  endtask

  task automatic resend();
    @(negedge clk); resendReq = 1;
    @(negedge clk); resendReq = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    tag = "R1";
    idle(2);
    check("R1 dlvValid after reset", int'(dlvValid), 0);
    check("R1 queueBusy after reset", int'(queueBusy), 0);
    cfgOp(0, 16, 0, 0);
    check("R1 prio after reset", int'(respPrio), 8'hFF);
    check("R4 read status", int'(respStatus), 0);
    // R2: range
    tag = "R2";
    cfgOp(0, 15, 0, 0);
    check("R2 num 15 refused", int'(respStatus), 8'hFD);
    cfgOp(0, 22, 0, 0);
    check("R2 num 22 refused", int'(respStatus), 8'hFD);
    cfgOp(0, 21, 0, 0);
    check("R2 num 21 accepted", int'(respStatus), 0);
    // R3: write validation
    tag = "R3";
    cfgOp(1, 17, 3, 5);
    check("R3 server 3 refused", int'(respStatus), 8'hFD);
    cfgOp(1, 17, 2, 256);
    check("R3 prio 256 refused", int'(respStatus), 8'hFD);
    cfgOp(1, 40, 0, 5);
    check("R3 num 40 refused", int'(respStatus), 8'hFD);
    cfgOp(0, 17, 0, 0);
    check("R3 refused write left prio", int'(respPrio), 8'hFF);
    cfgOp(1, 17, 2, 5);
    check("R3 good write", int'(respStatus), 0);
    tag = "R4";
    cfgOp(0, 17, 0, 0);
    check("R4 read server", int'(respServer), 2);
    check("R4 read prio", int'(respPrio), 5);
    // R5: edge trigger
    tag = "R5";
    @(negedge clk); trigIn = 6'b000010;
    @(negedge clk);
    check("R5 delivered", int'(dlvValid), 1);
    check("R5 number", int'(dlvNum), 17);
    check("R5 server", int'(dlvServer), 2);
    idle(4);
    check("R5 held level no retrigger", int'(dlvValid), 0);
    trigIn = '0;
    // R6: masked pending
    tag = "R6";
    pulse(6'b001000);
    check("R6 masked no delivery", int'(dlvValid), 0);
    cfgOp(1, 19, 1, 8'hFF);
    check("R6 still masked", int'(dlvValid), 0);
    cfgOp(1, 19, 1, 4);
    check("R6 unmask delivers", int'(dlvNum), 19);
    check("R6 unmask prio", int'(dlvPrio), 4);
    idle(2);
    // R9: ordering
    tag = "R9";
    cfgOp(1, 16, 0, 7);
    cfgOp(1, 18, 1, 3);
    cfgOp(1, 20, 2, 9);
    @(negedge clk); trigIn = 6'b010101;
    @(negedge clk); trigIn = '0;
    check("R9 first 16", int'(dlvNum), 16);
    @(negedge clk);
    check("R9 second 18", int'(dlvNum), 18);
    @(negedge clk);
    check("R9 third 20", int'(dlvNum), 20);
    idle(2);
    // R7: reject and resend
    tag = "R7";
    reject(18);
    reject(99);
    check("R7 no delivery before resend", int'(dlvValid), 0);
    resend();
    check("R7 resend delivers 18", int'(dlvNum), 18);
    idle(2);
    resend();
    check("R7 second resend empty", int'(dlvValid), 0);
    // R8: rejected while masked
    tag = "R8";
    reject(21);
    resend();
    cfgOp(1, 21, 0, 2);
    check("R8 no delivery after unmask", int'(dlvValid), 0);
    idle(2);
    // R10: end of interrupt
    tag = "R10";
    @(negedge clk); eoiValid = 1; eoiNum = W'(16);
    @(negedge clk); eoiValid = 0;
    check("R10 ack", int'(eoiAck), 1);
    check("R10 no delivery", int'(dlvValid), 0);
    @(negedge clk); eoiValid = 1; eoiNum = W'(30);
    @(negedge clk); eoiValid = 0;
    check("R10 invalid not acked", int'(eoiAck), 0);
    cfgOp(0, 16, 0, 0);
    check("R10 config unchanged", int'(respPrio), 7);
    idle(3);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule